// File: doc/BRIEF.md
# Pipelined converter digital error correction

This block sits behind the analog pipeline of a nine-stage converter. It turns the raw stage decisions for each sample into one corrected 10-bit output code. Stages one to eight each give a redundant three-level digit (-1, 0 or +1). Stage nine gives a plain 2-bit flash value. Adjacent coarse stages differ in weight by a factor of two. The digits overlap by one bit, so a comparator whose threshold has drifted is cancelled by the stages after it and no output code goes missing.

A sample moves one stage per half sample period. The block therefore runs on a step clock at twice the sample rate, and stage k's digit for a sample reaches the inputs k-1 steps after stage one's digit. The strobe travels with the stage-one digit. Each earlier stage's digit is delayed by one more step than the stage after it, so all nine digits of one sample meet in the same step. They are then summed into a registered output code with a valid flag.

Top module: `adcc_pipe_corrector`

## Requirements
- R1: While rst_n is low, and after its release until the first sample completes, code_vld_o is 0 and code_o is 0.
- R2: Each coarse digit is a 2-bit field: 2'b00 = -1, 2'b01 = 0, 2'b10 = +1. The code 2'b11 counts as 0. Stage k sits in crs_dig_i bits [2k-1:2k-2].
- R3: The output is code = 512 + sum over k=1..8 of d_k*2^(9-k) + (q - 2), where d_k is stage k's digit and q is the unsigned value of fine_dig_i. Every input combination lands in 0..1023.
- R4: Stage k's digit (k = 2..8) is read k-1 steps after the step that carries the strobe. fine_dig_i is read 8 steps after it. Input values in any other step have no effect on any output code.
- R5: code_o and code_vld_o present a sample's result in the tenth step after the step that carried its strobe (nine edges after the edge that captures the strobe). code_vld_o is high for that one step. code_o holds its last value until the next result.
- R6: Strobes are at least two steps apart and may have gaps of any length. A step without a strobe leads to no valid output; code_vld_o is never high in two steps in a row.
- R7: A stage-one digit of +1 gives a code of at least 512. A stage-one digit of -1 gives a code of at most 511.
- R8: Given the digits of an ideal residue model whose coarse comparator thresholds (nominally +-1/4 of full scale) are each shifted by less than 1/4 of full scale, and an ideal stage-nine flash, the code equals floor(512*(x+1)) for any input x in [-1, 1).
- R9: An input at negative full scale gives code 0. An input one step below positive full scale gives code 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | 1 | Strobe marking the step that carries a sample's stage-one digit |
| crs_dig_i | input | 16 | Eight 2-bit coarse digits, stage k at bits [2k-1:2k-2] |
| fine_dig_i | input | 2 | Stage-nine 2-bit flash value |
| code_o | output | 10 | Corrected output code |
| code_vld_o | output | 1 | High in the step that presents a new code |

## Verification
The hardest case to reach from the ports is a continuous stream. In that case every input step carries digits of up to five different samples at once. A delay line that is one step short or long then reads a neighbour's digit instead of failing in an obvious way. The stimulus streams samples back to back with random gaps that shift the step parity, and drives random junk on every digit lane that no sample owns in that step. Each sample's digits come from a residue model with random threshold offsets up to nearly a quarter of full scale, so residues often fall close to a shifted comparator threshold.

// File: rtl/adcc_pkg.sv
`timescale 1ns/1ps
package adcc_pkg;

    typedef logic [1:0] rawdig_t;

    // three-level coarse digit after decode
    typedef enum logic [1:0] {
        TRI_NEG  = 2'd0,
        TRI_ZERO = 2'd1,
        TRI_POS  = 2'd2
    } tri_e;

    localparam rawdig_t RAW_NEG  = 2'b00;
    localparam rawdig_t RAW_ZERO = 2'b01;
    localparam rawdig_t RAW_POS  = 2'b10;

    // the unused code 2'b11 is read as a zero digit
    function automatic tri_e decode_dig(input rawdig_t raw);
        tri_e res;
        unique case (raw)
            RAW_NEG: res = TRI_NEG;
            RAW_POS: res = TRI_POS;
            default: res = TRI_ZERO;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/adcc_skew_line.sv
`timescale 1ns/1ps
module adcc_skew_line #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] sr [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sr[i] <= '0;
            end
        end else begin
            sr[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q_o = sr[DEPTH-1];

endmodule

// File: rtl/adcc_digit_dec.sv
`timescale 1ns/1ps
module adcc_digit_dec
    import adcc_pkg::*;
#(
    parameter int NSTG = 8
) (
    input  rawdig_t raw_i [NSTG],
    output tri_e    dig_o [NSTG]
);

    for (genvar g = 0; g < NSTG; g++) begin : g_dec
        assign dig_o[g] = decode_dig(raw_i[g]);
    end

endmodule

// File: rtl/adcc_overlap_sum.sv
`timescale 1ns/1ps
module adcc_overlap_sum
    import adcc_pkg::*;
#(
    parameter int NSTG = 8,
    localparam int OUTW = NSTG + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  tri_e            dig_i [NSTG],
    input  logic [1:0]      fine_i,
    output logic [OUTW-1:0] code_o,
    output logic            vld_o
);

    localparam int MIDV     = 1 << (OUTW - 1);
    localparam int FINE_MID = 2;
    localparam logic [OUTW-1:0] MID_CODE = OUTW'(MIDV);

    logic [OUTW-1:0] acc;
    logic            all_zero;

    // modular sum: the exact result always fits in OUTW bits
    always_comb begin
        acc = OUTW'(MIDV + int'(fine_i) - FINE_MID);
        for (int g = 0; g < NSTG; g++) begin
            unique case (dig_i[g])
                TRI_POS:  acc = acc + OUTW'(1 << (NSTG - g));
                TRI_NEG:  acc = acc - OUTW'(1 << (NSTG - g));
                default:  acc = acc;
            endcase
        end
    end

    always_comb begin
        all_zero = 1'b1;
        for (int g = 0; g < NSTG; g++) begin
            if (dig_i[g] != TRI_ZERO) all_zero = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) code_o <= acc;
        end
    end

    // R7
    top_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dig_i[0] == TRI_POS) |=> (code_o >= MID_CODE))
        else $error("stage-one +1 gave a code below mid-scale");

    // R7
    low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && dig_i[0] == TRI_NEG) |=> (code_o < MID_CODE))
        else $error("stage-one -1 gave a code at or above mid-scale");

    // R3
    mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && all_zero && fine_i == 2'd2) |=> (code_o == MID_CODE))
        else $error("all-zero digits did not give mid-scale");

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(code_o))
        else $error("code changed without a sample");

    // R6
    vld_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o)
        else $error("valid high in two consecutive steps");

endmodule

// File: rtl/adcc_pipe_corrector.sv
`timescale 1ns/1ps
module adcc_pipe_corrector
    import adcc_pkg::*;
#(
    parameter int NSTG = 8,
    localparam int OUTW = NSTG + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld_i,
    input  logic [NSTG-1:0][1:0] crs_dig_i,
    input  logic [1:0]           fine_dig_i,
    output logic [OUTW-1:0]      code_o,
    output logic                 code_vld_o
);

    // stage k (1-based) arrives k-1 steps after the strobe; all meet NSTG steps later
    localparam int ALIGN = NSTG + 1;

    rawdig_t    crs_al [NSTG];
    tri_e       dig_al [NSTG];
    logic [1:0] fine_al;
    logic       vld_al;

    for (genvar g = 0; g < NSTG; g++) begin : g_skew
        adcc_skew_line #(.W(2), .DEPTH(ALIGN - g)) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (crs_dig_i[g]),
            .q_o   (crs_al[g])
        );
    end

    adcc_skew_line #(.W(2), .DEPTH(1)) u_fine_line (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fine_dig_i),
        .q_o   (fine_al)
    );

    adcc_skew_line #(.W(1), .DEPTH(ALIGN)) u_vld_line (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (smp_vld_i),
        .q_o   (vld_al)
    );

    adcc_digit_dec #(.NSTG(NSTG)) u_dec (
        .raw_i (crs_al),
        .dig_o (dig_al)
    );

    adcc_overlap_sum #(.NSTG(NSTG)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_al),
        .dig_i  (dig_al),
        .fine_i (fine_al),
        .code_o (code_o),
        .vld_o  (code_vld_o)
    );

    // R6
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |=> !smp_vld_i)
        else $error("strobes in two consecutive steps");

endmodule

// File: tb/tb_adcc_pipe_corrector.sv
`timescale 1ns/1ps
module tb_adcc_pipe_corrector;

    localparam int S  = 1 << 20;
    localparam int NS = 8;
    localparam int NV = 12;
    localparam int VX [NV] = '{-1048576, 1048575, 0, -1, 2047, 2048,
                               -2049, 262144, -262144, 524287, 1000000, -700000};
    localparam int VE [NV] = '{0, 1023, 512, 511, 512, 513,
                               510, 640, 384, 767, 1000, 170};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n;
    logic                smp_vld;
    logic [NS-1:0][1:0]  crs;
    logic [1:0]          fine;
    logic [9:0]          code;
    logic                code_vld;

    adcc_pipe_corrector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld_i  (smp_vld),
        .crs_dig_i  (crs),
        .fine_dig_i (fine),
        .code_o     (code),
        .code_vld_o (code_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    int last_code = 0;
    bit         rv [16];
    logic [1:0] rd [16][NS];
    logic [1:0] rq [16];
    int         re [16];
    string      rtag [16];
    int         offh [NS];
    int         offl [NS];
    logic [1:0] md [NS];
    logic [1:0] mq;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (step %0d)", req, act, exp, t);
        end
    endtask

    // ideal residue model with shifted coarse thresholds, ideal last flash
    function automatic void model(input int x);
        int r;
        int f;
        r = x;
        for (int k = 0; k < NS; k++) begin
            if (r > S/4 + offh[k]) begin
                md[k] = 2'b10; r = 2*r - S;
            end else if (r < -S/4 + offl[k]) begin
                md[k] = 2'b00; r = 2*r + S;
            end else begin
                md[k] = 2'b01; r = 2*r;
            end
        end
        f = (2*r) >>> 20;
        if (f < -2) f = -2;
        if (f > 1)  f = 1;
        mq = 2'(f + 2);
    endfunction

    function automatic int dig_val(input logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b00) return -1;
        return 0;
    endfunction

    // R3 formula
    function automatic int ref_code();
        int s;
        s = 512 + int'(mq) - 2;
        for (int k = 0; k < NS; k++) s = s + dig_val(md[k]) * (1 << (8 - k));
        return s;
    endfunction

    task automatic step(input bit v, input int e, input string tag);
        int slot;
        int src;
        bit ev;
        slot = t % 16;
        rv[slot] = v; rd[slot] = md; rq[slot] = mq; re[slot] = e; rtag[slot] = tag;
        if (t >= 10) begin
            src = (t - 10) % 16;
            ev  = rv[src];
            check("R5/R6 valid", int'(code_vld), int'(ev));
            if (ev) begin
                check(rtag[src], int'(code), re[src]);
                last_code = re[src];
            end else begin
                check("R5 hold", int'(code), last_code);
            end
        end else begin
            check("R1 valid", int'(code_vld), 0);
        end
        smp_vld = v;
        for (int k = 0; k < NS; k++) begin
            if (t - k >= 0 && rv[(t - k) % 16]) crs[k] = rd[(t - k) % 16][k];
            else crs[k] = 2'($urandom);   // R4 junk on unowned lanes
        end
        if (t - 8 >= 0 && rv[(t - 8) % 16]) fine = rq[(t - 8) % 16];
        else fine = 2'($urandom);
        t++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic analog(input int x, input int e, input string tag);
        model(x);
        step(1'b1, e, tag);
        step(1'b0, 0, "");
    endtask

    task automatic digits(input string tag);
        step(1'b1, ref_code(), tag);
        step(1'b0, 0, "");
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rv[i] = 1'b0;
        for (int k = 0; k < NS; k++) md[k] = 2'b01;
        mq = 2'd2;
        rst_n = 1'b0; smp_vld = 1'b0; crs = '0; fine = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(code_vld), 0);
        check("R1 reset code", int'(code), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NS; k++) begin
            offh[k] = int'($urandom_range(0, S/2 - 2)) - (S/4 - 1);
            offl[k] = int'($urandom_range(0, S/2 - 2)) - (S/4 - 1);
        end

        // table of inputs and expected codes (R8, R9 extremes first)
        for (int i = 0; i < NV; i++) analog(VX[i], VE[i], "R8/R9 table");

        // R2: illegal code reads as zero
        for (int k = 0; k < NS; k++) md[k] = 2'b01;
        md[0] = 2'b11; mq = 2'd2;
        step(1'b1, 512, "R2 illegal");
        step(1'b0, 0, "");
        md[0] = 2'b10; md[2] = 2'b11; mq = 2'd3;
        step(1'b1, 769, "R2 mixed");
        step(1'b0, 0, "");
        for (int q = 0; q < 4; q++) begin
            for (int k = 0; k < NS; k++) md[k] = 2'b01;
            mq = 2'(q);
            step(1'b1, 510 + q, "R3 fine");
            step(1'b0, 0, "");
        end

        // R7 corners of the overlap
        for (int k = 0; k < NS; k++) md[k] = 2'b00;
        md[0] = 2'b10; mq = 2'd0;
        step(1'b1, 512, "R7 upper");
        step(1'b0, 0, "");
        for (int k = 0; k < NS; k++) md[k] = 2'b10;
        md[0] = 2'b00; mq = 2'd3;
        step(1'b1, 511, "R7 lower");
        step(1'b0, 0, "");

        // R3 random digit patterns with all four codes
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < NS; k++) md[k] = 2'($urandom);
            mq = 2'($urandom);
            digits("R3 random");
        end

        // R8 inputs right at the shifted stage-one thresholds
        for (int dl = -1; dl <= 1; dl++) begin
            analog(S/4 + offh[0] + dl, (S/4 + offh[0] + dl + S) >>> 11, "R8 edge");
            analog(-S/4 + offl[0] + dl, (-S/4 + offl[0] + dl + S) >>> 11, "R8 edge");
        end

        // R8 random stream with R6 gaps
        for (int i = 0; i < 1500; i++) begin
            int x;
            x = int'($urandom_range(0, 2*S - 1)) - S;
            analog(x, (x + S) >>> 11, "R8 stream");
            if ($urandom_range(0, 7) == 0) begin
                for (int g = 0; g < int'($urandom_range(1, 3)); g++) step(1'b0, 0, "");
            end
        end

        for (int i = 0; i < 12; i++) step(1'b0, 0, "");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule